// File: doc/BRIEF.md
# Debug Hart Handshake Flag Controller

This block is the rendezvous point between a debugger and the harts that sit in a debug wait loop. Each halted hart polls one flag byte in a 4 KB memory-mapped window. It also reports its progress by writing status words to a few fixed handshake offsets. On the debugger side the block takes a hart select, a request to run an abstract command (go) and a request to leave debug mode (resume). It returns which harts are halted, a one-cycle resume acknowledgement per hart, a busy indication and a sticky command error.

The debugger sets flags. Only the hart concerned clears them, by writing the matching handshake offset. A halted hart rewrites its halted status on every loop iteration. Because of this, a controller that was reset through the active input learns the halted set again without any help from software. Hart reads are answered combinationally in the same cycle. The debugger-side state updates on the clock edge after a request.

Top module: `dbg_flag_ctrl`

## Requirements
- R1: While `rst_n` is low, or on any clock edge where `dmactive` is low, every flag, the halted vector, `busy` and `cmd_err` clear to zero.
- R2: A write to offset 0x100 whose data is a hart index below `N_HARTS` sets that hart's `halted` bit. Repeating the write changes nothing. An out-of-range index has no effect.
- R3: A `go_req` pulse sets the go flag (bit 0 of the flag byte) of the hart named by `hartsel` only if that hart is halted and `busy` is low. An accepted pulse raises `busy` on the next edge. A refused pulse changes neither the flags nor `busy`.
- R4: A write to offset 0x104 clears the go flag of the hart named by `hartsel`. If a command is running, a later write to offset 0x100 ends `busy`.
- R5: Any write to offset 0x10C sets `cmd_err` and drops `busy`. `cmd_err` then holds until `dmactive` goes low.
- R6: A `resume_req` pulse sets the resume flag (bit 1 of the flag byte) of the selected hart only if that hart is halted. Otherwise the pulse is ignored.
- R7: A write to offset 0x108 whose data is a hart index clears that hart's resume flag and its `halted` bit. It also raises `resume_ack` for that hart for exactly one cycle, one cycle after the write.
- R8: A read of the 32-bit word at 0x400 + 4w returns, in byte lane k, the flag byte of hart 4w + k. That byte is nonzero only when the hart is the one named by `hartsel`.
- R9: When a hart-side clear and a debugger-side set of the same flag fall in the same cycle, the flag ends cleared.
- R10: Reads of any other offset return zero, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmactive | input | 1 | Debug module active; low clears all state synchronously |
| bus_valid | input | 1 | Hart-side access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset inside the debug window |
| bus_wdata | input | 32 | Write data (hart index for status writes) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| hartsel | input | HART_W | Hart chosen by the debugger |
| go_req | input | 1 | Request to start a command on the selected hart |
| resume_req | input | 1 | Request to resume the selected hart |
| halted | output | N_HARTS | Per-hart halted status |
| resume_ack | output | N_HARTS | One-cycle resume acknowledgement per hart |
| busy | output | 1 | Abstract command in progress |
| cmd_err | output | 1 | Sticky exception error |

## Verification
The bench goes after refused requests. These are a go request to a running hart, a go request while busy, and a resume request to a hart that is not halted. A design that skipped the qualification would expose a flag byte the hart would then act on. The bench drives a resume request and the matching hart acknowledgement into the same cycle. A design with the wrong priority would leave a stale resume flag behind, and the hart would resume a second time. The bench also reads the flag word under a different `hartsel`, repeats and overflows halted writes, and checks the one-cycle shape of the acknowledgement and the stickiness of the error. These catch leaks of a flag to the wrong hart, halted bits set by bogus indices, and an error that clears itself.

// File: rtl/dbg_flag_pkg.sv
package dbg_flag_pkg;
   localparam int unsigned WIN_AW  = 12;
   localparam int unsigned BUS_DW  = 32;
   localparam int unsigned LANES   = BUS_DW / 8;

   localparam logic [WIN_AW-1:0] OFF_HALTED   = 12'h100;
   localparam logic [WIN_AW-1:0] OFF_GOING    = 12'h104;
   localparam logic [WIN_AW-1:0] OFF_RESUMING = 12'h108;
   localparam logic [WIN_AW-1:0] OFF_EXCEPT   = 12'h10C;
   localparam logic [WIN_AW-1:0] OFF_FLAGS    = 12'h400;
   localparam int unsigned       FLAG_SPAN    = 12'h400;

   localparam int unsigned BIT_GO     = 0;
   localparam int unsigned BIT_RESUME = 1;

   typedef enum logic [2:0] {
      HS_NONE,
      HS_HALTED,
      HS_GOING,
      HS_RESUMING,
      HS_EXCEPT
   } hs_wr_e;
endpackage

// File: rtl/dbg_flag_decode.sv
module dbg_flag_decode
   import dbg_flag_pkg::*;
#(
   parameter int unsigned N_HARTS = 4,
   localparam int unsigned FLAG_WORDS = (N_HARTS + LANES - 1) / LANES,
   localparam int unsigned FW = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1
) (
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [WIN_AW-1:0] bus_addr,
   output hs_wr_e            wr_kind,
   output logic              flag_rd,
   output logic [FW-1:0]     flag_word
);
   logic [WIN_AW-3:0] widx;
   logic [WIN_AW-1:0] frel;

   assign widx = bus_addr[WIN_AW-1:2];
   assign frel = bus_addr - OFF_FLAGS;

   always_comb begin
      wr_kind = HS_NONE;
      if (bus_valid && bus_write) begin
         if (widx == OFF_HALTED[WIN_AW-1:2])        wr_kind = HS_HALTED;
         else if (widx == OFF_GOING[WIN_AW-1:2])    wr_kind = HS_GOING;
         else if (widx == OFF_RESUMING[WIN_AW-1:2]) wr_kind = HS_RESUMING;
         else if (widx == OFF_EXCEPT[WIN_AW-1:2])   wr_kind = HS_EXCEPT;
      end
   end

   assign flag_rd = bus_valid && !bus_write && (bus_addr >= OFF_FLAGS)
                    && (32'(frel) < 32'(FLAG_WORDS * LANES));
   assign flag_word = FW'(frel[WIN_AW-1:2]);
endmodule

// File: rtl/dbg_hart_flags.sv
module dbg_hart_flags
   import dbg_flag_pkg::*;
#(
   parameter int unsigned N_HARTS = 4,
   localparam int unsigned HW = (N_HARTS > 1) ? $clog2(N_HARTS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dmactive,
   input  logic [HW-1:0]      hartsel,
   input  logic               go_req,
   input  logic               resume_req,
   input  logic               busy,
   input  hs_wr_e             wr_kind,
   input  logic [BUS_DW-1:0]  wr_id,
   output logic [N_HARTS-1:0] go_vec,
   output logic [N_HARTS-1:0] res_vec,
   output logic [N_HARTS-1:0] halted_vec,
   output logic [N_HARTS-1:0] resume_ack,
   output logic               go_accept
);
   logic [N_HARTS-1:0] go_set_v;

   for (genvar i = 0; i < N_HARTS; i++) begin : g_hart
      logic sel, id_hit, go_set, go_clr, res_set, res_clr, halt_set;
      assign sel      = (hartsel == HW'(i));
      assign id_hit   = (wr_id == BUS_DW'(i));
      assign go_set   = go_req && sel && halted_vec[i] && !busy;
      assign go_clr   = (wr_kind == HS_GOING) && sel;
      assign res_set  = resume_req && sel && halted_vec[i];
      assign res_clr  = (wr_kind == HS_RESUMING) && id_hit;
      assign halt_set = (wr_kind == HS_HALTED) && id_hit;
      assign go_set_v[i] = go_set;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            go_vec[i]     <= 1'b0;
            res_vec[i]    <= 1'b0;
            halted_vec[i] <= 1'b0;
            resume_ack[i] <= 1'b0;
         end else if (!dmactive) begin
            go_vec[i]     <= 1'b0;
            res_vec[i]    <= 1'b0;
            halted_vec[i] <= 1'b0;
            resume_ack[i] <= 1'b0;
         end else begin
            if (go_clr)       go_vec[i] <= 1'b0;
            else if (go_set)  go_vec[i] <= 1'b1;
            if (res_clr)      res_vec[i] <= 1'b0;
            else if (res_set) res_vec[i] <= 1'b1;
            if (res_clr)       halted_vec[i] <= 1'b0;
            else if (halt_set) halted_vec[i] <= 1'b1;
            resume_ack[i] <= res_clr;
         end
      end

      assert_go_needs_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(go_vec[i]) |-> $past(halted_vec[i]));
      assert_resume_needs_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(res_vec[i]) |-> $past(halted_vec[i]));
      assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (dmactive && res_clr) |=> !res_vec[i]);
   end

   assign go_accept = |go_set_v;

   assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(resume_ack));
endmodule

// File: rtl/dbg_cmd_tracker.sv
module dbg_cmd_tracker
   import dbg_flag_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   dmactive,
   input  logic   go_accept,
   input  hs_wr_e wr_kind,
   output logic   busy,
   output logic   cmd_err
);
   logic going_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cmd_err    <= 1'b0;
         going_seen <= 1'b0;
      end else if (!dmactive) begin
         busy       <= 1'b0;
         cmd_err    <= 1'b0;
         going_seen <= 1'b0;
      end else if (wr_kind == HS_EXCEPT) begin
         cmd_err    <= 1'b1;
         busy       <= 1'b0;
         going_seen <= 1'b0;
      end else if (busy && wr_kind == HS_GOING) begin
         going_seen <= 1'b1;
      end else if (busy && going_seen && wr_kind == HS_HALTED) begin
         busy       <= 1'b0;
         going_seen <= 1'b0;
      end else if (go_accept) begin
         busy       <= 1'b1;
         going_seen <= 1'b0;
      end
   end

   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_err && dmactive) |=> cmd_err);
   assert_except_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == HS_EXCEPT) |=> (!busy && cmd_err));
   assert_halt_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && going_seen && wr_kind == HS_HALTED) |=> !busy);
   assert_inactive_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !dmactive |=> (!busy && !cmd_err));
endmodule

// File: rtl/dbg_flag_ctrl.sv
module dbg_flag_ctrl
   import dbg_flag_pkg::*;
#(
   parameter int unsigned N_HARTS = 4,
   localparam int unsigned HART_W = (N_HARTS > 1) ? $clog2(N_HARTS) : 1,
   localparam int unsigned FLAG_WORDS = (N_HARTS + LANES - 1) / LANES,
   localparam int unsigned FW = (FLAG_WORDS > 1) ? $clog2(FLAG_WORDS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dmactive,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [11:0]        bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [HART_W-1:0]  hartsel,
   input  logic               go_req,
   input  logic               resume_req,
   output logic [N_HARTS-1:0] halted,
   output logic [N_HARTS-1:0] resume_ack,
   output logic               busy,
   output logic               cmd_err
);
   if (N_HARTS < 1 || N_HARTS > FLAG_SPAN) begin : g_bad_harts
      $error("dbg_flag_ctrl: N_HARTS must lie in 1..1024");
   end
   if (BUS_DW != 32) begin : g_bad_dw
      $error("dbg_flag_ctrl: bus must be 32 bits wide");
   end

   hs_wr_e             wr_kind;
   logic               flag_rd;
   logic [FW-1:0]      flag_word;
   logic [N_HARTS-1:0] go_vec, res_vec;
   logic               go_accept;
   logic [FLAG_WORDS*BUS_DW-1:0] flag_bytes;

   dbg_flag_decode #(.N_HARTS(N_HARTS)) u_dec (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .wr_kind   (wr_kind),
      .flag_rd   (flag_rd),
      .flag_word (flag_word)
   );

   dbg_hart_flags #(.N_HARTS(N_HARTS)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .dmactive   (dmactive),
      .hartsel    (hartsel),
      .go_req     (go_req),
      .resume_req (resume_req),
      .busy       (busy),
      .wr_kind    (wr_kind),
      .wr_id      (bus_wdata),
      .go_vec     (go_vec),
      .res_vec    (res_vec),
      .halted_vec (halted),
      .resume_ack (resume_ack),
      .go_accept  (go_accept)
   );

   dbg_cmd_tracker u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .dmactive  (dmactive),
      .go_accept (go_accept),
      .wr_kind   (wr_kind),
      .busy      (busy),
      .cmd_err   (cmd_err)
   );

   for (genvar h = 0; h < FLAG_WORDS * LANES; h++) begin : g_byte
      if (h < N_HARTS) begin : g_live
         assign flag_bytes[h*8 +: 8] = (hartsel == HART_W'(h))
            ? {6'b0, res_vec[h], go_vec[h]} : 8'h00;
      end else begin : g_pad
         assign flag_bytes[h*8 +: 8] = 8'h00;
      end
   end

   assign bus_rdata = flag_rd ? flag_bytes[flag_word*BUS_DW +: BUS_DW] : '0;

   assert_other_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr < OFF_FLAGS) |-> (bus_rdata == 32'h0));
endmodule

// File: tb/dbg_flag_ctrl_tb.sv
`timescale 1ns/100ps
module dbg_flag_ctrl_tb_top;
   localparam int unsigned N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dmactive = 1'b1;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  hartsel = '0;
   logic        go_req = 1'b0, resume_req = 1'b0;
   logic [N-1:0] halted, resume_ack;
   logic        busy, cmd_err;

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   dbg_flag_ctrl #(.N_HARTS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .dmactive(dmactive),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hartsel(hartsel), .go_req(go_req), .resume_req(resume_req),
      .halted(halted), .resume_ack(resume_ack), .busy(busy), .cmd_err(cmd_err)
   );

   // monitor: pops expected read data, compares mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (bus_valid && !bus_write) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
               fails++;
               $display("FAIL %s read @%h got %h exp %h", t, bus_addr, bus_rdata, e);
            end
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s got %h exp %h", req, act, exp);
      end
   endtask

   task automatic bus_access(input logic wr, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      #1;
   endtask

   task automatic expect_read(input string req, input logic [11:0] a, input logic [31:0] e);
      exp_q.push_back(e);
      tag_q.push_back(req);
      bus_access(1'b0, a, 32'h0);
   endtask

   task automatic pulse_go();
      @(negedge clk); go_req = 1'b1;
      @(negedge clk); go_req = 1'b0;
      #1;
   endtask

   task automatic pulse_resume();
      @(negedge clk); resume_req = 1'b1;
      @(negedge clk); resume_req = 1'b0;
      #1;
   endtask

   initial begin
      #(5.0 * 20000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 halted", 32'(halted), 32'h0);
      check("R1 busy", 32'(busy), 32'h0);
      check("R1 err", 32'(cmd_err), 32'h0);
      expect_read("R1 flags", 12'h400, 32'h0);

      // R3 go to non-halted hart refused
      hartsel = 2'd1;
      pulse_go();
      check("R3 refused busy", 32'(busy), 32'h0);
      expect_read("R3 refused flag", 12'h400, 32'h0);

      // R2 halted marking, idempotent, out of range ignored
      bus_access(1'b1, 12'h100, 32'd1);
      check("R2 halted set", 32'(halted), 32'h2);
      bus_access(1'b1, 12'h100, 32'd1);
      check("R2 idempotent", 32'(halted), 32'h2);
      bus_access(1'b1, 12'h100, 32'd9);
      check("R2 out of range", 32'(halted), 32'h2);
      bus_access(1'b1, 12'h100, 32'd2);
      check("R2 second hart", 32'(halted), 32'h6);

      // R3 accepted go, R8 visibility
      pulse_go();
      check("R3 busy", 32'(busy), 32'h1);
      expect_read("R8 go byte lane1", 12'h400, 32'h0000_0100);
      hartsel = 2'd2;
      expect_read("R8 masked other hart", 12'h400, 32'h0);
      pulse_go();
      expect_read("R3 busy blocks go", 12'h400, 32'h0);

      // R4 going then halted ends busy
      hartsel = 2'd1;
      bus_access(1'b1, 12'h104, 32'd1);
      expect_read("R4 go cleared", 12'h400, 32'h0);
      check("R4 still busy", 32'(busy), 32'h1);
      bus_access(1'b1, 12'h100, 32'd1);
      check("R4 busy ends", 32'(busy), 32'h0);

      // R5 exception
      pulse_go();
      bus_access(1'b1, 12'h104, 32'd1);
      bus_access(1'b1, 12'h10C, 32'h0);
      check("R5 busy drop", 32'(busy), 32'h0);
      check("R5 err set", 32'(cmd_err), 32'h1);
      bus_access(1'b1, 12'h100, 32'd1);
      check("R5 err sticky", 32'(cmd_err), 32'h1);

      // R6 / R7 resume
      hartsel = 2'd2;
      pulse_resume();
      expect_read("R6 resume byte lane2", 12'h400, 32'h0002_0000);
      bus_access(1'b1, 12'h108, 32'd2);
      check("R7 ack pulse", 32'(resume_ack), 32'h4);
      check("R7 halted cleared", 32'(halted), 32'h2);
      @(negedge clk); #1;
      check("R7 ack one cycle", 32'(resume_ack), 32'h0);
      expect_read("R7 resume cleared", 12'h400, 32'h0);
      hartsel = 2'd3;
      pulse_resume();
      expect_read("R6 non-halted ignored", 12'h400, 32'h0);

      // R9 same-cycle set and clear
      hartsel = 2'd1;
      @(negedge clk);
      resume_req = 1'b1;
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h108; bus_wdata = 32'd1;
      @(negedge clk);
      resume_req = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
      #1;
      check("R9 ack", 32'(resume_ack), 32'h2);
      check("R9 halted", 32'(halted), 32'h0);
      expect_read("R9 clear wins", 12'h400, 32'h0);

      // R10 other offsets
      bus_access(1'b1, 12'h100, 32'd1);
      bus_access(1'b1, 12'h110, 32'd3);
      bus_access(1'b1, 12'h200, 32'd3);
      check("R10 write ignored", 32'(halted), 32'h2);
      check("R10 busy unchanged", 32'(busy), 32'h0);
      expect_read("R10 read 0x100", 12'h100, 32'h0);
      expect_read("R10 read 0x200", 12'h200, 32'h0);

      // R1 dmactive clear
      pulse_resume();
      expect_read("R6 resume hart1", 12'h400, 32'h0000_0200);
      @(negedge clk); dmactive = 1'b0;
      @(negedge clk); dmactive = 1'b1;
      #1;
      check("R1 inactive halted", 32'(halted), 32'h0);
      check("R1 inactive err", 32'(cmd_err), 32'h0);
      expect_read("R1 inactive flags", 12'h400, 32'h0);

      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule